// File: doc/BRIEF.md
# Shared-RAM Receive Queue Pointer Controller

This block turns a 256-word window of a shared RAM into a first-in first-out queue for received characters, without holding any queue data itself. It keeps two 8-bit pointers: a fill pointer that names the next free word for the producer microcontroller, and a drain pointer that names the oldest stored word for the host. When the arbiter grants a queue access, the block puts the right pointer onto the RAM address bus. The pointer is offset by the base address of the window. When no queue access is granted, the bus is released. The RAM array and the arbiter sit outside this block.

The producer builds each entry with two byte writes: the status (high) byte first, then the character (low) byte. The fill pointer moves on only when the low byte completes the word. The host reads a whole word in one access. A 9-bit occupancy counter tells full from empty and drives the FULL, ALARM and EMPTY flags. The same flags go to the producer and to the host control register. If the host reads while the queue is empty, it gets a word marked invalid and the drain pointer does not move. If the producer writes while the queue is full, the write is dropped.

Top module: `rxq_ptr_ctrl`

## Requirements
- R1: After reset both pointers are 0, `empty_o`=1, `full_o`=0, `alarm_o`=0, and `ram_addr_oe_o`=0, `ram_we_o`=0.
- R2: A producer queue access is `prod_gnt_i & prod_fifo_wr_i`, and a host queue access is `host_gnt_i & host_fifo_rd_i`. During either one, `ram_addr_oe_o`=1 and `ram_addr_o` equals BASE_ADDR plus that side's pointer. With no queue access, `ram_addr_oe_o`=0 and `ram_addr_o`=0.
- R3: A producer access with `prod_hi_i`=1 (status byte) is accepted when the queue is not full. It gives `ram_we_o`=1 and `ram_be_o`=2'b10, and it leaves the fill pointer unchanged. A following access with `prod_hi_i`=0 (character byte) gives `ram_we_o`=1 and `ram_be_o`=2'b01, and the fill pointer and occupancy each then advance by one.
- R4: A character-byte access with no status byte pending since the last completed word is dropped. It gives `ram_we_o`=0 and `ram_be_o`=2'b00, and the fill pointer does not change.
- R5: A host access while not empty returns `ram_rdata_i` on `host_rdata_o` with `host_rinvalid_o`=0. The drain pointer advances by one and occupancy falls by one.
- R6: A host access while empty gives `host_rinvalid_o`=1 and `host_rdata_o`=0, and the drain pointer stays put.
- R7: `full_o` is 1 exactly when occupancy is 256. A status-byte write while full is dropped (`ram_we_o`=0), so the character byte that follows it is dropped as well.
- R8: `alarm_o` is 1 exactly when occupancy is 192 words or more.
- R9: Both pointers wrap modulo 256, so the word after offset 255 goes to BASE_ADDR again.
- R10: `empty_o` is 1 exactly when occupancy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prod_gnt_i | input | 1 | Arbiter grant to the producer |
| prod_fifo_wr_i | input | 1 | Producer byte write aimed at the queue |
| prod_hi_i | input | 1 | 1: status (high) byte, 0: character (low) byte |
| host_gnt_i | input | 1 | Arbiter grant to the host |
| host_fifo_rd_i | input | 1 | Host word read of the queue |
| ram_rdata_i | input | 16 | Word read from the shared RAM |
| ram_addr_o | output | 10 | Queue address onto the RAM address bus |
| ram_addr_oe_o | output | 1 | Queue address is driving the bus |
| ram_we_o | output | 1 | Accepted producer byte write |
| ram_be_o | output | 2 | Byte lanes of the write, {high, low} |
| host_rdata_o | output | 16 | Word returned to the host |
| host_rinvalid_o | output | 1 | Returned word is not valid (queue empty) |
| full_o | output | 1 | Occupancy is 256 |
| alarm_o | output | 1 | Occupancy at or above the alarm level |
| empty_o | output | 1 | Occupancy is 0 |

## Verification
The assertions rely on the arbiter granting at most one queue access per cycle. They also rely on the grant and strobe being held steady across the clock edge that closes the access. The bench drives exactly one producer byte or one host read per access, changing inputs only on the falling edge. Its grant-without-strobe and strobe-without-grant cases never form a queue access on both sides at once. Expected addresses, lanes and flags come from a bench model of the two pointers, the pending status byte and the occupancy. This model is stepped by the same rules the requirements state.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_PROD = 2'd1,
    ACC_HOST = 2'd2
  } acc_e;

  localparam int unsigned LANE_HI = 1;
  localparam int unsigned LANE_LO = 0;
endpackage

// File: rtl/rxq_wr_side.sv
module rxq_wr_side #(
  parameter int unsigned PTR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic             hi_i,
  input  logic             full_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             push_o,
  output logic             we_o,
  output logic [1:0]       be_o
);
  import rxq_pkg::*;

  logic             hi_pend_q;
  logic [PTR_W-1:0] ptr_q;
  logic             hi_ok, lo_ok;

  // status byte only lands with room; char byte only after a status byte
  assign hi_ok = acc_i &  hi_i & ~full_i;
  assign lo_ok = acc_i & ~hi_i & hi_pend_q;

  always_comb begin
    be_o          = 2'b00;
    be_o[LANE_HI] = hi_ok;
    be_o[LANE_LO] = lo_ok;
  end

  assign we_o   = hi_ok | lo_ok;
  assign push_o = lo_ok;
  assign ptr_o  = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_pend_q <= 1'b0;
      ptr_q     <= '0;
    end else begin
      if (hi_ok)      hi_pend_q <= 1'b1;
      else if (lo_ok) hi_pend_q <= 1'b0;
      if (lo_ok)      ptr_q     <= ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/rxq_rd_side.sv
module rxq_rd_side #(
  parameter int unsigned PTR_W  = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              empty_i,
  input  logic [DATA_W-1:0] ram_rdata_i,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              pop_o,
  output logic              invalid_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [PTR_W-1:0] ptr_q;

  assign pop_o     = acc_i & ~empty_i;
  assign invalid_o = acc_i &  empty_i;
  assign rdata_o   = pop_o ? ram_rdata_i : '0;
  assign ptr_o     = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (pop_o) ptr_q <= ptr_q + 1'b1;
  end
endmodule

// File: rtl/rxq_level.sv
module rxq_level #(
  parameter int unsigned PTR_W     = 8,
  parameter int unsigned ALARM_LVL = 192
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  logic pop_i,
  output logic full_o,
  output logic alarm_o,
  output logic empty_o
);
  localparam int unsigned CNT_W  = PTR_W + 1;
  localparam logic [CNT_W-1:0] DEPTH_V = CNT_W'(1 << PTR_W);
  localparam logic [CNT_W-1:0] ALARM_V = CNT_W'(ALARM_LVL);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
  end

  assign full_o  = (cnt_q == DEPTH_V);
  assign empty_o = (cnt_q == '0);
  assign alarm_o = (cnt_q >= ALARM_V);
endmodule

// File: rtl/rxq_addr_mux.sv
module rxq_addr_mux #(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned PTR_W     = 8,
  parameter int unsigned BASE_ADDR = 256
) (
  input  rxq_pkg::acc_e     sel_i,
  input  logic [PTR_W-1:0]  wptr_i,
  input  logic [PTR_W-1:0]  rptr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              oe_o
);
  import rxq_pkg::*;

  localparam logic [ADDR_W-1:0] BASE_V  = ADDR_W'(BASE_ADDR);
  localparam bit                ALIGNED = (BASE_ADDR % (1 << PTR_W)) == 0;

  logic [PTR_W-1:0]  ptr;
  logic [ADDR_W-1:0] full_addr;

  always_comb begin
    ptr  = '0;
    oe_o = 1'b0;
    unique case (sel_i)
      ACC_PROD: begin ptr = wptr_i; oe_o = 1'b1; end
      ACC_HOST: begin ptr = rptr_i; oe_o = 1'b1; end
      default:  begin ptr = '0;     oe_o = 1'b0; end
    endcase
  end

  generate
    if (ALIGNED) begin : g_concat
      // aligned window: base supplies upper bits, no adder
      assign full_addr = {BASE_V[ADDR_W-1:PTR_W], ptr};
    end else begin : g_add
      assign full_addr = BASE_V + {{(ADDR_W-PTR_W){1'b0}}, ptr};
    end
  endgenerate

  assign addr_o = oe_o ? full_addr : '0;
endmodule

// File: rtl/rxq_ptr_ctrl.sv
module rxq_ptr_ctrl #(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned PTR_W     = 8,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned BASE_ADDR = 256,
  parameter int unsigned ALARM_LVL = 192
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prod_gnt_i,
  input  logic              prod_fifo_wr_i,
  input  logic              prod_hi_i,
  input  logic              host_gnt_i,
  input  logic              host_fifo_rd_i,
  input  logic [DATA_W-1:0] ram_rdata_i,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              ram_addr_oe_o,
  output logic              ram_we_o,
  output logic [1:0]        ram_be_o,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              host_rinvalid_o,
  output logic              full_o,
  output logic              alarm_o,
  output logic              empty_o
);
  import rxq_pkg::*;

  logic             acc_prod, acc_host;
  logic             push, pop;
  logic [PTR_W-1:0] wptr, rptr;
  acc_e             sel;

  assign acc_prod = prod_gnt_i & prod_fifo_wr_i;
  assign acc_host = host_gnt_i & host_fifo_rd_i;

  always_comb begin
    if (acc_prod)      sel = ACC_PROD;
    else if (acc_host) sel = ACC_HOST;
    else               sel = ACC_NONE;
  end

  rxq_wr_side #(.PTR_W(PTR_W)) i_wr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .acc_i  (acc_prod),
    .hi_i   (prod_hi_i),
    .full_i (full_o),
    .ptr_o  (wptr),
    .push_o (push),
    .we_o   (ram_we_o),
    .be_o   (ram_be_o)
  );

  rxq_rd_side #(.PTR_W(PTR_W), .DATA_W(DATA_W)) i_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_i       (acc_host & ~acc_prod),
    .empty_i     (empty_o),
    .ram_rdata_i (ram_rdata_i),
    .ptr_o       (rptr),
    .pop_o       (pop),
    .invalid_o   (host_rinvalid_o),
    .rdata_o     (host_rdata_o)
  );

  rxq_level #(.PTR_W(PTR_W), .ALARM_LVL(ALARM_LVL)) i_lvl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .pop_i   (pop),
    .full_o  (full_o),
    .alarm_o (alarm_o),
    .empty_o (empty_o)
  );

  rxq_addr_mux #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .BASE_ADDR(BASE_ADDR)) i_mux (
    .sel_i  (sel),
    .wptr_i (wptr),
    .rptr_i (rptr),
    .addr_o (ram_addr_o),
    .oe_o   (ram_addr_oe_o)
  );
endmodule

// File: rtl/rxq_ptr_ctrl_chk.sv
module rxq_ptr_ctrl_chk #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              prod_gnt_i,
  input logic              prod_fifo_wr_i,
  input logic              prod_hi_i,
  input logic              host_gnt_i,
  input logic              host_fifo_rd_i,
  input logic [ADDR_W-1:0] ram_addr_o,
  input logic              ram_addr_oe_o,
  input logic              ram_we_o,
  input logic [1:0]        ram_be_o,
  input logic [DATA_W-1:0] host_rdata_o,
  input logic              host_rinvalid_o,
  input logic              full_o,
  input logic              alarm_o,
  input logic              empty_o
);
  logic acc_p, acc_h;
  assign acc_p = prod_gnt_i & prod_fifo_wr_i;
  assign acc_h = host_gnt_i & host_fifo_rd_i;

  p_one_access_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_p && acc_h));

  p_bus_released_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_p || acc_h) |-> (!ram_addr_oe_o && ram_addr_o == '0));

  p_we_needs_grant_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (acc_p && $countones(ram_be_o) == 1));

  p_lanes_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_we_o |-> ram_be_o == 2'b00);

  p_empty_read_invalid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_h && empty_o) |-> (host_rinvalid_o && host_rdata_o == '0));

  p_empty_read_stays_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_h && empty_o) |=> empty_o);

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && acc_p && prod_hi_i) |-> !ram_we_o);

  p_full_leaves_by_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !acc_h) |=> full_o);

  p_full_implies_alarm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> (alarm_o && !empty_o));

  p_empty_no_alarm_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (!alarm_o && !full_o));

  p_valid_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_h && !empty_o) |-> !host_rinvalid_o);
endmodule

bind rxq_ptr_ctrl rxq_ptr_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .prod_gnt_i      (prod_gnt_i),
  .prod_fifo_wr_i  (prod_fifo_wr_i),
  .prod_hi_i       (prod_hi_i),
  .host_gnt_i      (host_gnt_i),
  .host_fifo_rd_i  (host_fifo_rd_i),
  .ram_addr_o      (ram_addr_o),
  .ram_addr_oe_o   (ram_addr_oe_o),
  .ram_we_o        (ram_we_o),
  .ram_be_o        (ram_be_o),
  .host_rdata_o    (host_rdata_o),
  .host_rinvalid_o (host_rinvalid_o),
  .full_o          (full_o),
  .alarm_o         (alarm_o),
  .empty_o         (empty_o)
);

// File: tb/test_rxq_ptr_ctrl.sv
module test_rxq_ptr_ctrl;
  localparam int unsigned BASE = 256;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        prod_gnt_i = 0, prod_fifo_wr_i = 0, prod_hi_i = 0;
  logic        host_gnt_i = 0, host_fifo_rd_i = 0;
  logic [15:0] ram_rdata_i = '0;
  logic [9:0]  ram_addr_o;
  logic        ram_addr_oe_o, ram_we_o;
  logic [1:0]  ram_be_o;
  logic [15:0] host_rdata_o;
  logic        host_rinvalid_o, full_o, alarm_o, empty_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model
  logic [7:0] m_fill = 0, m_drain = 0;
  int         m_cnt = 0;
  bit         m_pend = 0;

  always #10 clk_i = ~clk_i;

  rxq_ptr_ctrl i_rxq_ptr_ctrl (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_flags(string req);
    check({req, " empty"}, 32'(empty_o), 32'(m_cnt == 0));
    check({req, " full"},  32'(full_o),  32'(m_cnt == 256));
    check({req, " alarm"}, 32'(alarm_o), 32'(m_cnt >= 192));
  endtask

  task automatic prod_byte(string req, logic hi);
    logic       exp_we;
    logic [1:0] exp_be;
    @(negedge clk_i);
    prod_gnt_i = 1; prod_fifo_wr_i = 1; prod_hi_i = hi;
    exp_we = hi ? (m_cnt < 256) : m_pend;
    exp_be = exp_we ? (hi ? 2'b10 : 2'b01) : 2'b00;
    #2;
    check({req, " oe"},   32'(ram_addr_oe_o), 32'd1);
    check({req, " addr"}, 32'(ram_addr_o), BASE + 32'(m_fill));
    check({req, " we"},   32'(ram_we_o), 32'(exp_we));
    check({req, " be"},   32'(ram_be_o), 32'(exp_be));
    @(posedge clk_i);
    if (exp_we && hi) m_pend = 1;
    if (exp_we && !hi) begin m_pend = 0; m_fill++; m_cnt++; end
    @(negedge clk_i);
    prod_gnt_i = 0; prod_fifo_wr_i = 0; prod_hi_i = 0;
  endtask

  task automatic prod_word(string req);
    prod_byte(req, 1'b1);
    prod_byte(req, 1'b0);
  endtask

  task automatic host_rd(string req, logic [15:0] word);
    bit emp;
    @(negedge clk_i);
    host_gnt_i = 1; host_fifo_rd_i = 1; ram_rdata_i = word;
    emp = (m_cnt == 0);
    #2;
    check({req, " oe"},    32'(ram_addr_oe_o), 32'd1);
    check({req, " addr"},  32'(ram_addr_o), BASE + 32'(m_drain));
    check({req, " inval"}, 32'(host_rinvalid_o), 32'(emp));
    check({req, " data"},  32'(host_rdata_o), emp ? 32'd0 : 32'(word));
    check({req, " we"},    32'(ram_we_o), 32'd0);
    @(posedge clk_i);
    if (!emp) begin m_drain++; m_cnt--; end
    @(negedge clk_i);
    host_gnt_i = 0; host_fifo_rd_i = 0; ram_rdata_i = '0;
  endtask

  task automatic t_reset;
    #3;
    check("R1 oe", 32'(ram_addr_oe_o), 0);
    check("R1 we", 32'(ram_we_o), 0);
    check_flags("R1");
    rst_ni = 1;
  endtask

  task automatic t_gating;
    @(negedge clk_i);
    prod_gnt_i = 1; #2;
    check("R2 gnt only oe", 32'(ram_addr_oe_o), 0);
    check("R2 gnt only addr", 32'(ram_addr_o), 0);
    prod_gnt_i = 0; host_fifo_rd_i = 1; #2;
    check("R2 strobe only oe", 32'(ram_addr_oe_o), 0);
    check("R2 strobe only we", 32'(ram_we_o), 0);
    host_fifo_rd_i = 0;
  endtask

  task automatic t_word;
    prod_byte("R3 status", 1'b1);
    check_flags("R3 after status byte");
    prod_byte("R3 char", 1'b0);
    check_flags("R3 after char byte");
    check("R3 fill moved", 32'(m_fill), 1);
  endtask

  task automatic t_orphan;
    prod_byte("R4 orphan char", 1'b0);
    check_flags("R4 level unchanged");
    prod_word("R4 next word same slot");
    check("R4 fill", 32'(m_fill), 2);
  endtask

  task automatic t_read;
    host_rd("R5 read", 16'h81_41);
    host_rd("R5 read", 16'h00_5a);
    check_flags("R5 drained");
  endtask

  task automatic t_empty_read;
    host_rd("R6 empty read", 16'hdead);
    host_rd("R6 empty read again", 16'hbeef);
    check_flags("R6 still empty");
  endtask

  task automatic t_fill_full;
    while (m_cnt < 256) begin
      prod_word("R9 fill");
      check_flags("R8 level");
    end
    prod_byte("R7 status while full", 1'b1);
    prod_byte("R7 char after dropped status", 1'b0);
    check_flags("R7 full held");
    host_rd("R7 read from full", 16'h1234);
    check_flags("R7 room again");
    prod_word("R9 wrapped slot");
    check_flags("R7 full again");
  endtask

  task automatic t_drain;
    while (m_cnt > 0) begin
      host_rd("R9 drain", 16'(m_drain) ^ 16'h3c00);
      if (m_cnt == 191 || m_cnt == 192 || m_cnt == 0) check_flags("R10 level");
    end
    check("R9 pointers meet", 32'(m_drain), 32'(m_fill));
    host_rd("R10 read at empty", 16'h7777);
    check_flags("R10 empty");
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_gating();
    t_word();
    t_orphan();
    t_read();
    t_empty_read();
    t_fill_full();
    t_drain();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule